// File: doc/BRIEF.md
# Multi-Host Reconfiguration Bus Arbiter

This block lets a parameterised number of reconfiguration hosts (1 to 32) share one memory-mapped port into a transceiver reconfiguration engine. Each host raises a request bit when it wants to reconfigure. A round-robin picker hands ownership of the shared port to one requesting host at a time. While it owns the port, that host's write, read, address and write data are forwarded to the engine. The engine's waitrequest, read data and read-valid are returned to that host only.

The engine signals completion of a reconfiguration with a "configuration applied" pulse. The arbiter routes that pulse to the owning host and passes the host's acknowledge back to the engine. That completed handshake ends the ownership. Only one read may be in flight per owner. Ownership cannot move while a read is outstanding.

A build parameter selects one of two forms for the command and return paths. The first is purely combinational, with the fewest registers. The second inserts one register stage, which breaks the timing path and adds one cycle of latency in each direction.

Top module: `recfg_bus_arbiter`

## Requirements
- R1: At most one host owns the shared port at any time. Ownership is given only to a host whose request bit is set, in the clock edge after the arbiter sees it while no host owns the port.
- R2: Host selection is round-robin. The search starts at the host after the last owner and wraps from the highest index to 0. After reset, host 0 has first priority.
- R3: A host that does not own the port sees waitrequest high, read-valid low and read data of all zeros, whatever it drives.
- R4: The owner's write, read, address and write data appear on the engine port in the same cycle when the pipeline parameter is 0. The engine's waitrequest is then reflected on the owner's waitrequest in the same cycle.
- R5: Engine read data and read-valid reach only the owner. They arrive in the same cycle with the pipeline parameter at 0, and one cycle later with it at 1.
- R6: Once a read from the owner is accepted, the owner's waitrequest stays high and no new command reaches the engine until read-valid has returned to the owner. Ownership does not change while that read is outstanding.
- R7: The engine's applied signal reaches only the owning host, and only while that host's request bit is set. The engine's acknowledge equals the owner's acknowledge bit. Acknowledges from other hosts are ignored.
- R8: After the edge where applied and acknowledge are both high, the owner's waitrequest goes high and no new command reaches the engine. Ownership is released on the next edge, provided no read is outstanding and the pipeline stage is empty. The next owner is granted one edge after that.
- R9: With the pipeline parameter at 1, a command held in the stage stays on the engine port until the engine drops waitrequest. Each accepted host command reaches the engine exactly once.
- R10: During reset no host owns the port. Engine write and read are low, every host waitrequest is high, and no applied or acknowledge signal is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the reconfiguration engine |
| rst | input | 1 | Synchronous active-high reset shared with the engine |
| host_req | input | HOSTS | Per-host request bit |
| host_wr | input | HOSTS | Per-host write strobe |
| host_rd | input | HOSTS | Per-host read strobe |
| host_addr | input | HOSTS*ADDR_W | Per-host address, host i at bits [i*ADDR_W +: ADDR_W] |
| host_wdata | input | HOSTS*DATA_W | Per-host write data |
| host_rdata | output | HOSTS*DATA_W | Per-host read data, zero for non-owners |
| host_wait | output | HOSTS | Per-host waitrequest |
| host_rvalid | output | HOSTS | Per-host read-valid |
| host_applied | output | HOSTS | Per-host configuration-applied notice |
| host_applied_ack | input | HOSTS | Per-host acknowledge of the applied notice |
| eng_wr | output | 1 | Write strobe to the engine |
| eng_rd | output | 1 | Read strobe to the engine |
| eng_addr | output | ADDR_W | Address to the engine |
| eng_wdata | output | DATA_W | Write data to the engine |
| eng_rdata | input | DATA_W | Read data from the engine |
| eng_rvalid | input | 1 | Read-valid from the engine |
| eng_wait | input | 1 | Waitrequest from the engine |
| eng_applied | input | 1 | Configuration-applied notice from the engine |
| eng_applied_ack | output | 1 | Acknowledge returned to the engine |

## Verification
The completion handshake can fall in the same cycle as an outstanding read. The release logic must then hold ownership until the read data has come back. The bench provokes this by issuing a read from the owner and then giving applied and acknowledge before read-valid returns. It judges the result by checking that the read data still reaches the same host. The next owner must appear exactly two edges after the data returns.

The second overlap occurs when the pipeline stage is full and the engine stalls while the host presents a new command. The bench judges this case by tracking the engine address cycle by cycle, so that each command appears once and none is dropped.

// File: rtl/recfg_arb_pkg.sv
package recfg_arb_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_OWN  = 1'b1
    } arb_phase_e;

endpackage

// File: rtl/recfg_rr_pick.sv
module recfg_rr_pick #(
    parameter int HOSTS = 4,
    parameter int IDXW  = (HOSTS > 1) ? $clog2(HOSTS) : 1
) (
    input  logic [HOSTS-1:0] req,
    input  logic [IDXW-1:0]  last,
    output logic             found,
    output logic [HOSTS-1:0] pick,
    output logic [IDXW-1:0]  pick_idx
);

    int idx;

    // Scan from the host after the last owner, wrapping once around.
    always_comb begin
        found    = 1'b0;
        pick     = '0;
        pick_idx = '0;
        idx      = 0;
        for (int k = 1; k <= HOSTS; k++) begin
            idx = (int'(last) + k) % HOSTS;
            if (!found && req[idx]) begin
                found     = 1'b1;
                pick[idx] = 1'b1;
                pick_idx  = IDXW'(idx);
            end
        end
    end

endmodule

// File: rtl/recfg_cmd_path.sv
module recfg_cmd_path #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter bit PIPE_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_wr,
    input  logic              in_rd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              in_wait,
    output logic [DATA_W-1:0] out_rdata,
    output logic              out_rvalid,
    output logic              busy,
    output logic              eng_wr,
    output logic              eng_rd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic [DATA_W-1:0] eng_rdata,
    input  logic              eng_rvalid,
    input  logic              eng_wait
);

    generate
        if (PIPE_EN == 1'b0) begin : g_comb
            logic unused_clkrst;
            assign unused_clkrst = clk ^ rst;
            assign eng_wr     = in_wr;
            assign eng_rd     = in_rd;
            assign eng_addr   = in_addr;
            assign eng_wdata  = in_wdata;
            assign in_wait    = eng_wait;
            assign out_rdata  = eng_rdata;
            assign out_rvalid = eng_rvalid;
            assign busy       = 1'b0;
        end else begin : g_pipe
            typedef struct packed {
                logic              vld;
                logic              wr;
                logic              rd;
                logic [ADDR_W-1:0] addr;
                logic [DATA_W-1:0] wdata;
                logic              rv;
                logic [DATA_W-1:0] rdata;
            } stage_t;

            stage_t stg_q, stg_d;
            logic   stall;
            logic   take;

            assign stall = stg_q.vld & eng_wait;
            assign take  = (in_wr | in_rd) & ~stall;

            always_comb begin
                stg_d = stg_q;
                if (stg_q.vld && !eng_wait) begin
                    stg_d.vld = 1'b0;
                end
                if (take) begin
                    stg_d.vld   = 1'b1;
                    stg_d.wr    = in_wr;
                    stg_d.rd    = in_rd;
                    stg_d.addr  = in_addr;
                    stg_d.wdata = in_wdata;
                end
                stg_d.rv    = eng_rvalid;
                stg_d.rdata = eng_rdata;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q <= '0;
                end else begin
                    stg_q <= stg_d;
                end
            end

            assign in_wait    = stall;
            assign eng_wr     = stg_q.vld & stg_q.wr;
            assign eng_rd     = stg_q.vld & stg_q.rd;
            assign eng_addr   = stg_q.addr;
            assign eng_wdata  = stg_q.wdata;
            assign out_rdata  = stg_q.rdata;
            assign out_rvalid = stg_q.rv;
            assign busy       = stg_q.vld;
        end
    endgenerate

endmodule

// File: rtl/recfg_bus_arbiter.sv
module recfg_bus_arbiter
    import recfg_arb_pkg::*;
#(
    parameter int HOSTS   = 4,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter bit PIPE_EN = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [HOSTS-1:0]         host_req,
    input  logic [HOSTS-1:0]         host_wr,
    input  logic [HOSTS-1:0]         host_rd,
    input  logic [HOSTS*ADDR_W-1:0]  host_addr,
    input  logic [HOSTS*DATA_W-1:0]  host_wdata,
    output logic [HOSTS*DATA_W-1:0]  host_rdata,
    output logic [HOSTS-1:0]         host_wait,
    output logic [HOSTS-1:0]         host_rvalid,
    output logic [HOSTS-1:0]         host_applied,
    input  logic [HOSTS-1:0]         host_applied_ack,
    output logic                     eng_wr,
    output logic                     eng_rd,
    output logic [ADDR_W-1:0]        eng_addr,
    output logic [DATA_W-1:0]        eng_wdata,
    input  logic [DATA_W-1:0]        eng_rdata,
    input  logic                     eng_rvalid,
    input  logic                     eng_wait,
    input  logic                     eng_applied,
    output logic                     eng_applied_ack
);

    localparam int IDXW = (HOSTS > 1) ? $clog2(HOSTS) : 1;

    typedef struct packed {
        arb_phase_e       phase;
        logic [HOSTS-1:0] grant;
        logic [IDXW-1:0]  last;
        logic             rd_pend;
        logic             done_seen;
    } arb_t;

    arb_t s_q, s_d;

    logic              pick_found;
    logic [HOSTS-1:0]  pick_vec;
    logic [IDXW-1:0]   pick_idx;

    logic              sel_wr, sel_rd;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              cmd_block;
    logic              p_wr, p_rd, p_wait, p_rvalid, p_busy;
    logic [DATA_W-1:0] p_rdata;
    logic              rd_accept;
    logic              handshake;

    // Names the bound checker looks at.
    logic [HOSTS-1:0]  grant_vec;
    logic              rd_pend_w;
    assign grant_vec = s_q.grant;
    assign rd_pend_w = s_q.rd_pend;

    recfg_rr_pick #(
        .HOSTS (HOSTS),
        .IDXW  (IDXW)
    ) u_pick (
        .req      (host_req),
        .last     (s_q.last),
        .found    (pick_found),
        .pick     (pick_vec),
        .pick_idx (pick_idx)
    );

    // Owner's command selected through the one-hot grant.
    always_comb begin
        sel_wr    = 1'b0;
        sel_rd    = 1'b0;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < HOSTS; i++) begin
            sel_wr    = sel_wr | (host_wr[i] & s_q.grant[i]);
            sel_rd    = sel_rd | (host_rd[i] & s_q.grant[i]);
            sel_addr  = sel_addr  | (host_addr[i*ADDR_W +: ADDR_W]  & {ADDR_W{s_q.grant[i]}});
            sel_wdata = sel_wdata | (host_wdata[i*DATA_W +: DATA_W] & {DATA_W{s_q.grant[i]}});
        end
    end

    assign cmd_block = s_q.rd_pend | s_q.done_seen;
    assign p_wr      = sel_wr & ~cmd_block;
    assign p_rd      = sel_rd & ~cmd_block;

    recfg_cmd_path #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PIPE_EN (PIPE_EN)
    ) u_path (
        .clk        (clk),
        .rst        (rst),
        .in_wr      (p_wr),
        .in_rd      (p_rd),
        .in_addr    (sel_addr),
        .in_wdata   (sel_wdata),
        .in_wait    (p_wait),
        .out_rdata  (p_rdata),
        .out_rvalid (p_rvalid),
        .busy       (p_busy),
        .eng_wr     (eng_wr),
        .eng_rd     (eng_rd),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .eng_rdata  (eng_rdata),
        .eng_rvalid (eng_rvalid),
        .eng_wait   (eng_wait)
    );

    assign rd_accept       = p_rd & ~p_wait;
    assign eng_applied_ack = |(s_q.grant & host_applied_ack);
    assign handshake       = eng_applied & eng_applied_ack;

    generate
        for (genvar g = 0; g < HOSTS; g++) begin : g_host
            assign host_wait[g]    = ~s_q.grant[g] | cmd_block | p_wait;
            assign host_rvalid[g]  = s_q.grant[g] & p_rvalid;
            assign host_rdata[g*DATA_W +: DATA_W] = s_q.grant[g] ? p_rdata : '0;
            assign host_applied[g] = eng_applied & s_q.grant[g] & host_req[g];
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            ARB_IDLE: begin
                if (pick_found) begin
                    s_d.phase     = ARB_OWN;
                    s_d.grant     = pick_vec;
                    s_d.last      = pick_idx;
                    s_d.rd_pend   = 1'b0;
                    s_d.done_seen = 1'b0;
                end
            end
            ARB_OWN: begin
                if (rd_accept) begin
                    s_d.rd_pend = 1'b1;
                end
                if (s_q.rd_pend && p_rvalid) begin
                    s_d.rd_pend = 1'b0;
                end
                if (handshake) begin
                    s_d.done_seen = 1'b1;
                end
                if (s_q.done_seen && !s_q.rd_pend && !p_busy) begin
                    s_d.phase     = ARB_IDLE;
                    s_d.grant     = '0;
                    s_d.done_seen = 1'b0;
                end
            end
            default: s_d.phase = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.phase     <= ARB_IDLE;
            s_q.grant     <= '0;
            s_q.last      <= IDXW'(HOSTS - 1);
            s_q.rd_pend   <= 1'b0;
            s_q.done_seen <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/recfg_arb_checker.sv
module recfg_arb_checker #(
    parameter int HOSTS  = 4,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [HOSTS-1:0]        host_wait,
    input logic [HOSTS-1:0]        host_rvalid,
    input logic [HOSTS*DATA_W-1:0] host_rdata,
    input logic [HOSTS-1:0]        host_applied,
    input logic                    eng_wr,
    input logic                    eng_rd,
    input logic [HOSTS-1:0]        grant_vec,
    input logic                    rd_pend,
    input logic                    busy
);

    a_r1_single_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~host_wait));

    a_r7_applied_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(host_applied));

    a_r6_grant_held_on_read: assert property (@(posedge clk) disable iff (rst)
        rd_pend |=> $stable(grant_vec));

    a_r6_no_cmd_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd_pend && !busy) |-> (!eng_wr && !eng_rd));

    a_r8_release_via_idle: assert property (@(posedge clk) disable iff (rst)
        (grant_vec != '0) |=> ((grant_vec == $past(grant_vec)) || (grant_vec == '0)));

    generate
        for (genvar i = 0; i < HOSTS; i++) begin : g_chk
            a_r3_idle_host_quiet: assert property (@(posedge clk) disable iff (rst)
                !grant_vec[i] |-> (host_wait[i] && !host_rvalid[i]
                                   && (host_rdata[i*DATA_W +: DATA_W] == '0)));
            a_r7_applied_to_owner: assert property (@(posedge clk) disable iff (rst)
                host_applied[i] |-> grant_vec[i]);
        end
    endgenerate

endmodule

bind recfg_bus_arbiter recfg_arb_checker #(
    .HOSTS  (HOSTS),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_wait    (host_wait),
    .host_rvalid  (host_rvalid),
    .host_rdata   (host_rdata),
    .host_applied (host_applied),
    .eng_wr       (eng_wr),
    .eng_rd       (eng_rd),
    .grant_vec    (grant_vec),
    .rd_pend      (rd_pend_w),
    .busy         (p_busy)
);

// File: tb/recfg_bus_arbiter_test.sv
module recfg_bus_arbiter_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // Main instance: four hosts, combinational paths.
    logic [3:0]   en, wr, rd, ack;
    logic [39:0]  addr;
    logic [127:0] wdata;
    wire  [127:0] rdata;
    wire  [3:0]   hwait, hrv, happ;
    wire          ewr, erd, eack;
    wire  [9:0]   eaddr;
    wire  [31:0]  ewdata;
    logic [31:0]  erdata;
    logic         erv, ewait, eapp;

    recfg_bus_arbiter #(.HOSTS(4), .ADDR_W(10), .DATA_W(32), .PIPE_EN(1'b0)) uut (
        .clk(clk), .rst(rst), .host_req(en), .host_wr(wr), .host_rd(rd),
        .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
        .host_wait(hwait), .host_rvalid(hrv), .host_applied(happ),
        .host_applied_ack(ack), .eng_wr(ewr), .eng_rd(erd), .eng_addr(eaddr),
        .eng_wdata(ewdata), .eng_rdata(erdata), .eng_rvalid(erv),
        .eng_wait(ewait), .eng_applied(eapp), .eng_applied_ack(eack)
    );

    // Second instance: two hosts, register stage on.
    logic [1:0]   p_en, p_wr, p_rd, p_ack;
    logic [19:0]  p_addr;
    logic [63:0]  p_wdata;
    wire  [63:0]  p_rdata;
    wire  [1:0]   p_wait, p_rv, p_app;
    wire          p_ewr, p_erd, p_eack;
    wire  [9:0]   p_eaddr;
    wire  [31:0]  p_ewdata;
    logic [31:0]  p_erdata;
    logic         p_erv, p_ewait, p_eapp;

    recfg_bus_arbiter #(.HOSTS(2), .ADDR_W(10), .DATA_W(32), .PIPE_EN(1'b1)) uut_pipe (
        .clk(clk), .rst(rst), .host_req(p_en), .host_wr(p_wr), .host_rd(p_rd),
        .host_addr(p_addr), .host_wdata(p_wdata), .host_rdata(p_rdata),
        .host_wait(p_wait), .host_rvalid(p_rv), .host_applied(p_app),
        .host_applied_ack(p_ack), .eng_wr(p_ewr), .eng_rd(p_erd), .eng_addr(p_eaddr),
        .eng_wdata(p_ewdata), .eng_rdata(p_erdata), .eng_rvalid(p_erv),
        .eng_wait(p_ewait), .eng_applied(p_eapp), .eng_applied_ack(p_eack)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    // Completes the handshake for owner idx and checks the gap and next owner.
    task automatic finish_owner(input int idx, input logic [3:0] next_wait);
        @(negedge clk);
        eapp = 1'b1;
        ack = 4'b0000;
        ack[(idx + 1) % 4] = 1'b1;
        #1;
        check("R7 applied routed to owner", happ, 4'b0001 << idx);
        check("R7 non-owner ack ignored", eack, 1'b0);
        ack = 4'b0000;
        ack[idx] = 1'b1;
        #1;
        check("R7 owner ack forwarded", eack, 1'b1);
        @(negedge clk);
        eapp = 1'b0;
        ack = 4'b0000;
        #1;
        check("R8 owner blocked after handshake", hwait, 4'hF);
        tick();
        check("R8 idle gap after release", hwait, 4'hF);
        tick();
        check("R2 next owner", hwait, next_wait);
    endtask

    task automatic t_reset;
        #1;
        check("R10 reset waits", hwait, 4'hF);
        check("R10 reset eng write", ewr, 1'b0);
        check("R10 reset eng read", erd, 1'b0);
        check("R10 reset applied", happ, 4'h0);
        check("R10 reset ack", eack, 1'b0);
    endtask

    task automatic t_grant_and_write;
        @(negedge clk);
        en = 4'b0100;
        #1;
        check("R1 no owner before edge", hwait, 4'hF);
        @(negedge clk);
        wr[2] = 1'b1; addr[29:20] = 10'h155; wdata[95:64] = 32'hDEADBEEF;
        wr[1] = 1'b1; addr[19:10] = 10'h2AA; wdata[63:32] = 32'h11111111;
        #1;
        check("R1 single owner host2", hwait, 4'b1011);
        check("R4 eng write", ewr, 1'b1);
        check("R4 eng addr", eaddr, 10'h155);
        check("R4 eng wdata", ewdata, 32'hDEADBEEF);
        check("R3 non-owner waits", hwait[1], 1'b1);
        ewait = 1'b1;
        #1;
        check("R4 wait reflected", hwait[2], 1'b1);
        ewait = 1'b0;
        @(negedge clk);
        wr = 4'b0000;
    endtask

    task automatic t_read;
        @(negedge clk);
        rd[2] = 1'b1; addr[29:20] = 10'h0AB;
        #1;
        check("R4 eng read", erd, 1'b1);
        check("R4 read addr", eaddr, 10'h0AB);
        tick();
        check("R6 owner held during read", hwait[2], 1'b1);
        check("R6 no new read on engine", erd, 1'b0);
        erv = 1'b1; erdata = 32'hCAFE0001; rd = 4'b0000;
        #1;
        check("R5 rvalid to owner only", hrv, 4'b0100);
        check("R5 owner rdata", rdata[95:64], 32'hCAFE0001);
        check("R3 non-owner rdata zero", {rdata[127:96], rdata[63:0]}, 96'h0);
        @(negedge clk);
        erv = 1'b0;
        #1;
        check("R6 wait released after data", hwait[2], 1'b0);
    endtask

    task automatic t_round_robin;
        @(negedge clk);
        en = 4'b1101;
        finish_owner(2, 4'b0111);
        finish_owner(3, 4'b1110);
        finish_owner(0, 4'b1011);
        @(negedge clk);
        en = 4'b0100;
        finish_owner(2, 4'b1011);
    endtask

    task automatic t_done_during_read;
        @(negedge clk);
        rd[2] = 1'b1; addr[29:20] = 10'h033;
        @(negedge clk);
        rd = 4'b0000; eapp = 1'b1; ack[2] = 1'b1;
        #1;
        check("R7 ack during read", eack, 1'b1);
        @(negedge clk);
        eapp = 1'b0; ack = 4'b0000;
        #1;
        check("R6 blocked with read and done", hwait, 4'hF);
        tick();
        erv = 1'b1; erdata = 32'h0BADF00D;
        #1;
        check("R6 owner kept until read returns", hrv, 4'b0100);
        check("R6 read data kept", rdata[95:64], 32'h0BADF00D);
        @(negedge clk);
        erv = 1'b0;
        #1;
        check("R8 idle wait after read", hwait, 4'hF);
        tick();
        check("R8 released after read", hwait, 4'hF);
        tick();
        check("R8 regranted", hwait, 4'b1011);
    endtask

    task automatic t_applied_no_req;
        @(negedge clk);
        en = 4'b0000; eapp = 1'b1;
        #1;
        check("R7 applied withheld without request", happ, 4'h0);
        @(negedge clk);
        eapp = 1'b0; en = 4'b0100;
        #1;
        check("R7 ownership kept", hwait, 4'b1011);
        finish_owner(2, 4'b1011);
    endtask

    task automatic t_pipe;
        @(negedge clk);
        p_en = 2'b01;
        tick();
        check("R1 pipe owner", p_wait, 2'b10);
        check("R9 stage empty", p_ewr, 1'b0);
        p_ewait = 1'b1;
        p_wr[0] = 1'b1; p_addr[9:0] = 10'h101; p_wdata[31:0] = 32'hAAAA;
        #1;
        check("R9 empty stage accepts", p_wait[0], 1'b0);
        check("R9 one cycle latency", p_ewr, 1'b0);
        @(negedge clk);
        p_addr[9:0] = 10'h102; p_wdata[31:0] = 32'hBBBB;
        #1;
        check("R9 first cmd on engine", p_eaddr, 10'h101);
        check("R9 engine write", p_ewr, 1'b1);
        check("R9 full stage stalls host", p_wait[0], 1'b1);
        tick();
        check("R9 held under stall", p_eaddr, 10'h101);
        check("R9 held data", p_ewdata, 32'hAAAA);
        p_ewait = 1'b0;
        #1;
        check("R9 drain accepts next", p_wait[0], 1'b0);
        @(negedge clk);
        p_wr = 2'b00;
        #1;
        check("R9 second cmd once", p_eaddr, 10'h102);
        check("R9 second write", p_ewr, 1'b1);
        tick();
        check("R9 no duplicate", p_ewr, 1'b0);
        p_rd[0] = 1'b1; p_addr[9:0] = 10'h103;
        @(negedge clk);
        p_rd = 2'b00;
        #1;
        check("R9 read on engine", p_erd, 1'b1);
        tick();
        check("R9 read issued once", p_erd, 1'b0);
        p_erv = 1'b1; p_erdata = 32'h5A5A;
        #1;
        check("R5 pipe rvalid delayed", p_rv, 2'b00);
        @(negedge clk);
        p_erv = 1'b0;
        #1;
        check("R5 pipe rvalid owner", p_rv, 2'b01);
        check("R5 pipe rdata", p_rdata[31:0], 32'h5A5A);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog: actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        en = '0; wr = '0; rd = '0; ack = '0; addr = '0; wdata = '0;
        erdata = '0; erv = 1'b0; ewait = 1'b0; eapp = 1'b0;
        p_en = '0; p_wr = '0; p_rd = '0; p_ack = '0; p_addr = '0; p_wdata = '0;
        p_erdata = '0; p_erv = 1'b0; p_ewait = 1'b0; p_eapp = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_grant_and_write();
        t_read();
        t_round_robin();
        t_done_during_read();
        t_applied_no_req();
        t_pipe();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule